// File: doc/BRIEF.md
# Stack Operator Execution Unit

This unit carries out the operator group of a 16-bit stack machine's instruction set. The stack lives in byte-addressed memory, grows toward lower addresses, and is reached through a relocation base: the word at stack offset `X` sits at memory byte address `base + X`. When a sequencer pulses `start`, the unit captures a 12-bit operator code and the current stack pointer, relocation base, program counter and stack bottom. It reads the top word (at SP) and the word beneath it (at SP+2). It then fetches one memory operand when the operator needs it, computes the result and writes it back. Finally it pulses `done` and returns the new stack pointer and program counter.

The operators are wrapping 16-bit arithmetic, bitwise logic, signed comparisons, conditional and unconditional jumps through a stacked target, a jump that swaps the program counter with the top word, indirect load and store, exchange of the two top words, increment and decrement, and three kinds of constant-count shift. A code the unit does not handle, a stack too shallow for the operator, or a zero divisor each end the operation with a fault flag. In that case memory, SP and PC are left as they were.

Top module: `stack_op_unit`

## Requirements
- R1: A one-cycle `start` captures all inputs. Exactly one one-cycle `done` pulse follows, with `sp_out`, `pc_out` and the three fault flags valid while `done` is high. `pc_out` equals `pc_in` unless a jump is taken. Memory is byte addressed, and the word at stack offset X is at address `ra_in + X`. After reset `done`, `mem_we` and all fault flags are 0.
- R2: Codes 000 add, 001 subtract, 002 multiply, 003 divide, 005 AND, 006 OR, 007 XOR and 018 remainder take A = word at SP+2 and B = word at SP. They write A op B at SP+2 and add 2 to SP. Results wrap modulo 2^16. Divide and remainder are signed: the quotient is truncated toward zero and the remainder takes the sign of A.
- R3: Codes 004 NOT, 012 two's-complement negate, 013 absolute value (signed, with 0x8000 staying 0x8000), 01A increment and 01B decrement replace the word at SP in place. SP is unchanged.
- R4: Codes 008 equal, 009 not equal, 00A A<B, 00B A<=B, 00C A>B and 00D A>=B compare A (at SP+2) with B (at SP) as signed values. They write 0x0001 if true or 0x0000 if false at SP+2 and add 2 to SP.
- R5: Code 00E jumps when bit 0 of the word at SP+2 is 1, and code 00F jumps when that bit is 0. A jump loads PC from the word at SP. SP always increases by 4, and memory is not written.
- R6: Code 010 loads PC from the word at SP and adds 2 to SP. Code 011 loads PC from the word at SP, writes the old PC at SP, and leaves SP unchanged.
- R7: Codes 014 and 016 replace the word at SP with the memory word at `ra + (word at SP)`. Codes 015 and 017 write the word at SP to `ra + (word at SP+2)` and add 4 to SP.
- R8: Code 033 exchanges the words at SP and SP+2. SP is unchanged.
- R9: Codes 04n shift the word at SP left logically, 05n shift it right logically, and 06n shift it right arithmetically. In each case the count is n, the low 4 bits of the code, and the result is written in place.
- R10: An operator that consumes k stack words (k = 2 for the R2, R4, R5, R7-store and R8 codes, k = 1 otherwise) raises `fault_underflow` when SP + 2k > `fl_in`. It then writes nothing and returns SP and PC unchanged.
- R11: Divide or remainder with a zero word at SP raises `fault_divzero`, writes nothing and returns SP and PC unchanged.
- R12: Any code not listed in R2-R9 (for example 019, 030-032, 0FF) raises `fault_unsup`, writes nothing and returns SP and PC unchanged. At most one fault flag is set per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request; captures the inputs below |
| subop | input | 12 | Operator code |
| sp_in | input | 16 | Stack pointer (byte offset of top word) |
| ra_in | input | 16 | Relocation base added to every offset |
| pc_in | input | 16 | Program counter |
| fl_in | input | 16 | Stack bottom offset (empty stack has SP = fl_in) |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Read data, one cycle after the address |
| done | output | 1 | Completion pulse |
| sp_out | output | 16 | Updated stack pointer |
| pc_out | output | 16 | Updated program counter |
| fault_unsup | output | 1 | Code not handled |
| fault_underflow | output | 1 | Stack holds too few words |
| fault_divzero | output | 1 | Zero divisor |

## Verification
Operators are drawn at random over every handled code and over arbitrary 12-bit codes. Operand words are random, so the signed and unsigned readings of the comparisons, the remainder signs and the arithmetic shift fill bits all differ. Load and store operands are steered to in-range addresses, so an indirect access at the wrong address shows up as a mismatch in the memory image. Stack pointers are kept near the stack bottom, so the one-word and two-word underflow limits are each hit on both sides. Directed cases cover wrap at 0x7FFF+1, 0x8000 under absolute value and arithmetic shift, taken and untaken conditional jumps, a zero divisor, and unhandled codes.

// File: rtl/sop_pkg.sv
package sop_pkg;
    localparam int DW  = 16;
    localparam int OPW = 12;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD_TOP, ST_RD_NXT, ST_RD_REF, ST_EXEC, ST_WR1, ST_WR2, ST_DONE
    } st_e;

    // Result of one operator: up to two writes plus stack/PC updates
    typedef struct packed {
        logic          w1_en;     // write to SP+2 slot, or to referenced word
        logic          w1_ref;    // 1: address is base + word at SP+2
        logic [DW-1:0] w1_data;
        logic          w2_en;     // write to SP slot
        logic [DW-1:0] w2_data;
        logic [1:0]    pop_words; // SP grows by 2*pop_words
        logic          pc_ld;
        logic [DW-1:0] pc_val;
        logic          div_zero;
    } exec_t;

    function automatic logic [DW-1:0] flag_word(input logic c);
        return {{(DW-1){1'b0}}, c};
    endfunction
endpackage

// File: rtl/sop_decode.sv
module sop_decode
    import sop_pkg::*;
(
    input  logic [OPW-1:0] op,
    output logic           supported,
    output logic [1:0]     need_words
);
    always_comb begin
        supported  = 1'b1;
        need_words = 2'd2;
        casez (op)
            12'h000, 12'h001, 12'h002, 12'h003, 12'h005, 12'h006, 12'h007,
            12'h008, 12'h009, 12'h00A, 12'h00B, 12'h00C, 12'h00D,
            12'h00E, 12'h00F, 12'h015, 12'h017, 12'h018, 12'h033:
                need_words = 2'd2;
            12'h004, 12'h010, 12'h011, 12'h012, 12'h013, 12'h014, 12'h016,
            12'h01A, 12'h01B, 12'h04?, 12'h05?, 12'h06?:
                need_words = 2'd1;
            default: begin
                supported  = 1'b0;
                need_words = 2'd0;
            end
        endcase
    end
endmodule

// File: rtl/sop_alu.sv
module sop_alu
    import sop_pkg::*;
(
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0]  top,   // word at SP (B)
    input  logic [DW-1:0]  nxt,   // word at SP+2 (A)
    input  logic [DW-1:0]  mval,  // word at base + top
    input  logic [DW-1:0]  pc,
    output exec_t          res
);
    logic signed [DW-1:0] sa, sb, sdiv, quo, rem;
    logic [3:0] cnt;

    always_comb begin
        sa   = $signed(nxt);
        sb   = $signed(top);
        sdiv = (top == '0) ? DW'(1) : sb;
        quo  = sa / sdiv;
        rem  = sa % sdiv;
        cnt  = op[3:0];

        res           = '0;
        res.pc_val    = pc;
        res.w1_en     = 1'b1;
        res.pop_words = 2'd1;
        casez (op)
            12'h000: res.w1_data = nxt + top;
            12'h001: res.w1_data = nxt - top;
            12'h002: res.w1_data = nxt * top;
            12'h003: begin res.w1_data = quo; res.div_zero = (top == '0); end
            12'h018: begin res.w1_data = rem; res.div_zero = (top == '0); end
            12'h005: res.w1_data = nxt & top;
            12'h006: res.w1_data = nxt | top;
            12'h007: res.w1_data = nxt ^ top;
            12'h008: res.w1_data = flag_word(nxt == top);
            12'h009: res.w1_data = flag_word(nxt != top);
            12'h00A: res.w1_data = flag_word(sa <  sb);
            12'h00B: res.w1_data = flag_word(sa <= sb);
            12'h00C: res.w1_data = flag_word(sa >  sb);
            12'h00D: res.w1_data = flag_word(sa >= sb);
            12'h00E, 12'h00F: begin
                res.w1_en     = 1'b0;
                res.pop_words = 2'd2;
                res.pc_ld     = (nxt[0] == ~op[0]);
                res.pc_val    = res.pc_ld ? top : pc;
            end
            12'h010: begin res.w1_en = 1'b0; res.pc_ld = 1'b1; res.pc_val = top; end
            12'h011: begin
                res.w1_en = 1'b0; res.pop_words = 2'd0;
                res.pc_ld = 1'b1; res.pc_val = top;
                res.w2_en = 1'b1; res.w2_data = pc;
            end
            12'h015, 12'h017: begin
                res.w1_ref = 1'b1; res.w1_data = top; res.pop_words = 2'd2;
            end
            12'h033: begin
                res.w1_data = top; res.pop_words = 2'd0;
                res.w2_en = 1'b1; res.w2_data = nxt;
            end
            default: begin
                // in-place single-operand operators
                res.w1_en     = 1'b0;
                res.pop_words = 2'd0;
                res.w2_en     = 1'b1;
                casez (op)
                    12'h004: res.w2_data = ~top;
                    12'h012: res.w2_data = -top;
                    12'h013: res.w2_data = sb[DW-1] ? -top : top;
                    12'h014, 12'h016: res.w2_data = mval;
                    12'h01A: res.w2_data = top + 1'b1;
                    12'h01B: res.w2_data = top - 1'b1;
                    12'h04?: res.w2_data = top << cnt;
                    12'h05?: res.w2_data = top >> cnt;
                    12'h06?: res.w2_data = $unsigned(sb >>> cnt);
                    default: res.w2_en = 1'b0;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/stack_op_unit.sv
module stack_op_unit
    import sop_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [OPW-1:0] subop,
    input  logic [DW-1:0]  sp_in,
    input  logic [DW-1:0]  ra_in,
    input  logic [DW-1:0]  pc_in,
    input  logic [DW-1:0]  fl_in,
    output logic [DW-1:0]  mem_addr,
    output logic           mem_we,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    output logic           done,
    output logic [DW-1:0]  sp_out,
    output logic [DW-1:0]  pc_out,
    output logic           fault_unsup,
    output logic           fault_underflow,
    output logic           fault_divzero
);
    localparam logic [DW-1:0] WORD_BYTES = DW'(2);

    st_e            st;
    logic [OPW-1:0] op_l;
    logic [DW-1:0]  sp_l, ra_l, sp_q, pc_q, top_q, nxt_q;
    exec_t          res_q, alu_res;
    logic           dec_sup, short_stack;
    logic [1:0]     dec_need;

    sop_decode u_dec (.op(subop), .supported(dec_sup), .need_words(dec_need));

    sop_alu u_alu (
        .op(op_l), .top(top_q), .nxt(nxt_q), .mval(mem_rdata), .pc(pc_q), .res(alu_res)
    );

    assign short_stack = ({1'b0, sp_in} + {{(DW-2){1'b0}}, dec_need, 1'b0}) > {1'b0, fl_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
            op_l <= '0; sp_l <= '0; ra_l <= '0; sp_q <= '0; pc_q <= '0;
            top_q <= '0; nxt_q <= '0; res_q <= '0;
            fault_unsup <= 1'b0; fault_underflow <= 1'b0; fault_divzero <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    op_l <= subop;
                    sp_l <= sp_in;
                    sp_q <= sp_in;
                    ra_l <= ra_in;
                    pc_q <= pc_in;
                    fault_unsup     <= !dec_sup;
                    fault_underflow <= dec_sup && short_stack;
                    fault_divzero   <= 1'b0;
                    st <= (!dec_sup || short_stack) ? ST_DONE : ST_RD_TOP;
                end
                ST_RD_TOP: st <= ST_RD_NXT;
                ST_RD_NXT: begin top_q <= mem_rdata; st <= ST_RD_REF; end
                ST_RD_REF: begin nxt_q <= mem_rdata; st <= ST_EXEC; end
                ST_EXEC: begin
                    res_q <= alu_res;
                    if (alu_res.div_zero) begin
                        fault_divzero <= 1'b1;
                        st <= ST_DONE;
                    end else begin
                        sp_q <= sp_l + {{(DW-3){1'b0}}, alu_res.pop_words, 1'b0};
                        if (alu_res.pc_ld) pc_q <= alu_res.pc_val;
                        st <= ST_WR1;
                    end
                end
                ST_WR1:  st <= ST_WR2;
                ST_WR2:  st <= ST_DONE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_addr  = '0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        case (st)
            ST_RD_TOP: mem_addr = ra_l + sp_l;
            ST_RD_NXT: mem_addr = ra_l + sp_l + WORD_BYTES;
            ST_RD_REF: mem_addr = ra_l + top_q;
            ST_WR1: begin
                mem_addr  = res_q.w1_ref ? (ra_l + nxt_q) : (ra_l + sp_l + WORD_BYTES);
                mem_we    = res_q.w1_en;
                mem_wdata = res_q.w1_data;
            end
            ST_WR2: begin
                mem_addr  = ra_l + sp_l;
                mem_we    = res_q.w2_en;
                mem_wdata = res_q.w2_data;
            end
            default: ;
        endcase
    end

    assign done   = (st == ST_DONE);
    assign sp_out = sp_q;
    assign pc_out = pc_q;

    // R1: completion is a single-cycle pulse
    a_r1_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10, R11, R12: no memory write while a fault is pending
    a_r10_no_write_on_fault: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !(fault_unsup || fault_underflow || fault_divzero));

    // R12: at most one fault flag per operation
    a_r12_single_fault: assert property (@(posedge clk) disable iff (rst)
        done |-> $onehot0({fault_unsup, fault_underflow, fault_divzero}));

    // R5: conditional jumps always release two words
    a_r5_cond_pops_two: assert property (@(posedge clk) disable iff (rst)
        (done && !fault_underflow && (op_l == 12'h00E || op_l == 12'h00F))
            |-> (sp_out == sp_l + 16'd4));
endmodule

// File: tb/tb_stack_op_unit.sv
module tb_stack_op_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [11:0] subop = '0;
    logic [15:0] sp_in = '0, ra_in = '0, pc_in = '0, fl_in = '0;
    logic [15:0] mem_addr, mem_wdata, sp_out, pc_out;
    logic [15:0] mem_rdata = '0;
    logic        mem_we, done, fault_unsup, fault_underflow, fault_divzero;

    int checks = 0;
    int errors = 0;

    logic [15:0] mem     [0:1023];
    logic [15:0] exp_mem [0:1023];

    localparam logic [15:0] RA = 16'h0100;
    localparam logic [15:0] FL = 16'h0400;

    always #10 clk = ~clk;

    stack_op_unit dut (
        .clk(clk), .rst(rst), .start(start), .subop(subop),
        .sp_in(sp_in), .ra_in(ra_in), .pc_in(pc_in), .fl_in(fl_in),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .sp_out(sp_out), .pc_out(pc_out),
        .fault_unsup(fault_unsup), .fault_underflow(fault_underflow),
        .fault_divzero(fault_divzero)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[10:1]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[10:1]];
    end

    function automatic int ix(input logic [15:0] a);
        return int'(a[10:1]);
    endfunction

    function automatic int words_used(input logic [11:0] op);
        if (op inside {12'h000, 12'h001, 12'h002, 12'h003, 12'h005, 12'h006, 12'h007,
                       12'h008, 12'h009, 12'h00A, 12'h00B, 12'h00C, 12'h00D,
                       12'h00E, 12'h00F, 12'h015, 12'h017, 12'h018, 12'h033}) return 2;
        if (op inside {12'h004, 12'h010, 12'h011, 12'h012, 12'h013, 12'h014, 12'h016,
                       12'h01A, 12'h01B}) return 1;
        if (op[11:4] inside {8'h04, 8'h05, 8'h06}) return 1;
        return 0;
    endfunction

    function automatic string req_of(input logic [11:0] op);
        if (op inside {12'h000, 12'h001, 12'h002, 12'h003, 12'h005, 12'h006, 12'h007, 12'h018}) return "R2";
        if (op inside {12'h004, 12'h012, 12'h013, 12'h01A, 12'h01B}) return "R3";
        if (op inside {[12'h008:12'h00D]}) return "R4";
        if (op inside {12'h00E, 12'h00F}) return "R5";
        if (op inside {12'h010, 12'h011}) return "R6";
        if (op inside {[12'h014:12'h017]}) return "R7";
        if (op == 12'h033) return "R8";
        return "R9";
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Independent model of one operation; updates exp_mem
    task automatic model(input logic [11:0] op, input logic [15:0] sp, input logic [15:0] pc,
                         output logic [15:0] esp, output logic [15:0] epc,
                         output logic [2:0] eflt, output string req);
        logic [15:0] b, a, r;
        int sa, sb;
        int n;
        b  = exp_mem[ix(RA + sp)];
        a  = exp_mem[ix(RA + sp + 16'd2)];
        sa = int'($signed(a));
        sb = int'($signed(b));
        n  = words_used(op);
        esp = sp; epc = pc; eflt = 3'b000;
        if (n == 0) begin eflt = 3'b100; req = "R12"; return; end
        if (int'(sp) + 2 * n > int'(FL)) begin eflt = 3'b010; req = "R10"; return; end
        req = req_of(op);
        if ((op == 12'h003 || op == 12'h018) && b == 16'h0) begin
            eflt = 3'b001; req = "R11"; return;
        end
        case (op)
            12'h000, 12'h001, 12'h002, 12'h003, 12'h005, 12'h006, 12'h007, 12'h018,
            12'h008, 12'h009, 12'h00A, 12'h00B, 12'h00C, 12'h00D: begin
                case (op)
                    12'h000: r = 16'(sa + sb);
                    12'h001: r = 16'(sa - sb);
                    12'h002: r = 16'(sa * sb);
                    12'h003: r = 16'(sa / sb);
                    12'h018: r = 16'(sa % sb);
                    12'h005: r = a & b;
                    12'h006: r = a | b;
                    12'h007: r = a ^ b;
                    12'h008: r = (sa == sb) ? 16'd1 : 16'd0;
                    12'h009: r = (sa != sb) ? 16'd1 : 16'd0;
                    12'h00A: r = (sa <  sb) ? 16'd1 : 16'd0;
                    12'h00B: r = (sa <= sb) ? 16'd1 : 16'd0;
                    12'h00C: r = (sa >  sb) ? 16'd1 : 16'd0;
                    default: r = (sa >= sb) ? 16'd1 : 16'd0;
                endcase
                exp_mem[ix(RA + sp + 16'd2)] = r;
                esp = sp + 16'd2;
            end
            12'h00E: begin if (a[0] == 1'b1) epc = b; esp = sp + 16'd4; end
            12'h00F: begin if (a[0] == 1'b0) epc = b; esp = sp + 16'd4; end
            12'h010: begin epc = b; esp = sp + 16'd2; end
            12'h011: begin epc = b; exp_mem[ix(RA + sp)] = pc; end
            12'h015, 12'h017: begin exp_mem[ix(RA + a)] = b; esp = sp + 16'd4; end
            12'h033: begin exp_mem[ix(RA + sp)] = a; exp_mem[ix(RA + sp + 16'd2)] = b; end
            default: begin
                case (op[11:4])
                    8'h04: r = 16'(b << op[3:0]);
                    8'h05: r = b >> op[3:0];
                    8'h06: r = 16'(sb >>> op[3:0]);
                    default: case (op)
                        12'h004: r = ~b;
                        12'h012: r = 16'(-sb);
                        12'h013: r = 16'((sb < 0) ? -sb : sb);
                        12'h01A: r = 16'(sb + 1);
                        12'h01B: r = 16'(sb - 1);
                        default: r = exp_mem[ix(RA + b)]; // load
                    endcase
                endcase
                exp_mem[ix(RA + sp)] = r;
            end
        endcase
    endtask

    task automatic run_op(input logic [11:0] op, input logic [15:0] sp,
                          input logic [15:0] top, input logic [15:0] nx, input logic [15:0] pc);
        logic [15:0] esp, epc;
        logic [2:0]  eflt;
        string req;
        int waited;
        int bad;
        mem[ix(RA + sp)] = top;
        mem[ix(RA + sp + 16'd2)] = nx;
        for (int i = 0; i < 1024; i++) exp_mem[i] = mem[i];
        model(op, sp, pc, esp, epc, eflt, req);
        @(negedge clk);
        subop = op; sp_in = sp; pc_in = pc; ra_in = RA; fl_in = FL; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        waited = 0;
        while (!done && waited < 40) begin @(negedge clk); waited++; end
        if (!done) begin
            check("R1", "watchdog: done missing", 32'd0, 32'd1);
            return;
        end
        check(req, "sp_out", sp_out, esp);
        check(req, "pc_out", pc_out, epc);
        check(req, "faults", {fault_unsup, fault_underflow, fault_divzero}, eflt);
        @(negedge clk);
        check("R1", "done pulse width", done, 1'b0);
        bad = 0;
        for (int i = 0; i < 1024; i++) if (mem[i] !== exp_mem[i]) bad++;
        check(req, "memory words differing", bad, 0);
    endtask

    function automatic logic [11:0] pick_op(input int k);
        case (k)
            0: return 12'h000;  1: return 12'h001;  2: return 12'h002;  3: return 12'h003;
            4: return 12'h004;  5: return 12'h005;  6: return 12'h006;  7: return 12'h007;
            8: return 12'h008;  9: return 12'h009; 10: return 12'h00A; 11: return 12'h00B;
            12: return 12'h00C; 13: return 12'h00D; 14: return 12'h00E; 15: return 12'h00F;
            16: return 12'h010; 17: return 12'h011; 18: return 12'h012; 19: return 12'h013;
            20: return 12'h014; 21: return 12'h015; 22: return 12'h016; 23: return 12'h017;
            24: return 12'h018; 25: return 12'h01A; 26: return 12'h01B; 27: return 12'h033;
            28: return {8'h04, 4'($urandom)};
            29: return {8'h05, 4'($urandom)};
            30: return {8'h06, 4'($urandom)};
            default: return 12'($urandom);
        endcase
    endfunction

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < 1024; i++) mem[i] = 16'($urandom);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "reset done", done, 1'b0);
        check("R1", "reset mem_we", mem_we, 1'b0);
        check("R1", "reset faults", {fault_unsup, fault_underflow, fault_divzero}, 3'b000);

        // directed corner cases
        run_op(12'h000, 16'h0380, 16'h0001, 16'h7FFF, 16'h0040); // R2 wrap to 0x8000
        run_op(12'h003, 16'h0380, 16'h0004, 16'hFFF9, 16'h0040); // R2 -7/4 = -1
        run_op(12'h018, 16'h0380, 16'h0004, 16'hFFF9, 16'h0040); // R2 -7%4 = -3
        run_op(12'h00A, 16'h0380, 16'h0001, 16'hFFFF, 16'h0040); // R4 signed -1 < 1
        run_op(12'h013, 16'h0380, 16'h8000, 16'h0000, 16'h0040); // R3 abs 0x8000
        run_op(12'h06F, 16'h0380, 16'h8000, 16'h0000, 16'h0040); // R9 sar fill
        run_op(12'h05F, 16'h0380, 16'h8000, 16'h0000, 16'h0040); // R9 shr
        run_op(12'h00E, 16'h0380, 16'h0222, 16'h0003, 16'h0040); // R5 taken
        run_op(12'h00E, 16'h0380, 16'h0222, 16'h0002, 16'h0040); // R5 not taken
        run_op(12'h00F, 16'h0380, 16'h0222, 16'h0002, 16'h0040); // R5 taken on false
        run_op(12'h011, 16'h0380, 16'h0300, 16'h0000, 16'h0044); // R6 link
        run_op(12'h010, 16'h0380, 16'h0300, 16'h0000, 16'h0044); // R6 jump
        run_op(12'h014, 16'h0380, 16'h0010, 16'h0000, 16'h0044); // R7 load
        run_op(12'h015, 16'h0380, 16'hBEEF, 16'h0020, 16'h0044); // R7 store
        run_op(12'h033, 16'h0380, 16'h1111, 16'h2222, 16'h0044); // R8 swap
        run_op(12'h003, 16'h0380, 16'h0000, 16'h1234, 16'h0044); // R11 zero divisor
        run_op(12'h018, 16'h0380, 16'h0000, 16'h1234, 16'h0044); // R11 zero divisor
        run_op(12'h000, 16'h03FE, 16'h0001, 16'h0002, 16'h0044); // R10 one word only
        run_op(12'h000, 16'h03FC, 16'h0001, 16'h0002, 16'h0044); // R10 limit ok
        run_op(12'h01A, 16'h03FE, 16'hFFFF, 16'h0000, 16'h0044); // R3 inc at limit
        run_op(12'h01A, 16'h0400, 16'h0001, 16'h0000, 16'h0044); // R10 empty stack
        run_op(12'h030, 16'h0380, 16'h0001, 16'h0002, 16'h0044); // R12
        run_op(12'h019, 16'h0380, 16'h0001, 16'h0002, 16'h0044); // R12

        // random operations
        for (int t = 0; t < 1500; t++) begin
            logic [11:0] op;
            logic [15:0] sp, top, nx;
            op  = pick_op(int'($urandom % 34));
            sp  = ($urandom % 4 == 0) ? (16'h03F8 + 16'(($urandom % 5) * 2))
                                      : (16'h0300 + 16'(($urandom % 128) * 2));
            top = 16'($urandom);
            nx  = 16'($urandom);
            if (op == 12'h014 || op == 12'h016) top = 16'(($urandom % 16'h0380) * 2);
            if (op == 12'h015 || op == 12'h017) nx  = 16'(($urandom % 16'h0380) * 2);
            if ((op == 12'h003 || op == 12'h018) && ($urandom % 4 == 0)) top = 16'h0;
            if ((op == 12'h003 || op == 12'h018) && nx == 16'h8000 && top == 16'hFFFF) top = 16'h0001;
            run_op(op, sp, top, nx, 16'($urandom));
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule